// File: doc/BRIEF.md
# Overcurrent Fault Qualifier and Recovery Controller

This block watches the current-limit flags of the eight power switches in a dual H-bridge. Each bridge has two outputs, and each output has a high-side and a low-side switch. A bridge's flags are OR-ed together. They must stay high for longer than a programmable deglitch count before the bridge counts as faulted. A qualified fault does four things: it disables that bridge only, pulls the fault pin request low, sets the FAULT and OCP summary bits, and records which switches were limiting in sticky per-switch diagnostic bits.

Recovery follows the mode sampled at the moment of the trip. In latched mode the bridge stays off until a clear-fault pulse or a sleep-reset pulse arrives. In auto-retry mode the bridge stays off for a programmable retry count. After that count it comes back on if its flags are low. If they are still high, the retry count starts again.

Each bridge runs its own state machine. Its states are IDLE (no flag), QUAL (flag persisting, count running), LATCHED (off, waiting for a clear) and RETRY (off, retry count running). The transitions are:

- FLAG_SEEN: IDLE to QUAL.
- FLAG_DROP: QUAL to IDLE.
- TRIP: QUAL, or IDLE when the deglitch count is 0, to LATCHED or RETRY.
- CLEAR: LATCHED or RETRY to IDLE, on a clear pulse.
- RESUME: RETRY to IDLE.
- REARM: RETRY to RETRY, which restarts the retry count.
- SLEEP: any state to IDLE.

Top module: `ocp_fault_handler`

## Requirements
- R1: With deglitch count D, a bridge trips after the rising clock edge at which its OR-ed flags have been high for D+1 consecutive edges. That edge sets its `bridge_dis_o` bit. With D=0, a single edge is enough.
- R2: If the flags drop before a trip, the persistence count restarts. Flags high for D edges, then low, then high for D edges again, produce no fault.
- R3: A trip disables only the bridge that tripped. Bit 0 of `bridge_dis_o` is bridge A and bit 1 is bridge B.
- R4: On the edge that trips a bridge, `fault_o` and `ocp_o` go to 1 and `fault_pin_n_o` goes to 0. `fault_o` is 1 exactly while some bridge is disabled, and `fault_pin_n_o` is its inverse.
- R5: Flag and diagnostic index is b*4 + o*2 + s. Here b is 0 for bridge A and 1 for bridge B, o is 0 for output 1 and 1 for output 2, and s is 0 for the high-side switch and 1 for the low-side switch. An output shorted to supply limits the low-side switch, so its low-side bit is set. An output shorted to ground sets its high-side bit. At a trip, every flag of that bridge that is high is recorded.
- R6: With `retry_mode_i`=0 at the trip (latched mode), the bridge stays disabled even after the flags fall and even if the mode input changes, until a clear or sleep pulse arrives.
- R7: With `retry_mode_i`=1 at the trip, the bridge stays disabled for R cycles, where R is the retry count. It then releases if the flags are low: `fault_o` returns to 0 and `ocp_o` stays 1.
- R8: In auto-retry mode, if the flags are still high when the R cycles end, the bridge stays disabled and waits another R cycles.
- R9: `ocp_o` and `fet_diag_o` stay set in both modes until a clear or sleep pulse.
- R10: `clr_flt_i` returns LATCHED or RETRY bridges to IDLE and clears `ocp_o` and `fet_diag_o`. `sleep_rst_i` does the same and also drops any persistence count in progress.
- R11: After reset, no bridge is disabled, `fault_o`, `ocp_o` and `fet_diag_o` are 0, and `fault_pin_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilim_i | input | 8 | Per-switch current-limit flags (index per R5) |
| retry_mode_i | input | 1 | 0 = latched shutdown, 1 = auto-retry |
| clr_flt_i | input | 1 | Clear-fault pulse |
| sleep_rst_i | input | 1 | Sleep-reset pulse |
| deglitch_cyc_i | input | 16 | Deglitch count D |
| retry_cyc_i | input | 16 | Retry count R |
| bridge_dis_o | output | 2 | Per-bridge disable |
| fault_pin_n_o | output | 1 | Fault pin request, active low |
| fault_o | output | 1 | FAULT summary bit |
| ocp_o | output | 1 | Sticky OCP summary bit |
| fet_diag_o | output | 8 | Sticky per-switch diagnostic bits |

## Verification
The assertions assume the following about the inputs:
- The flags are synchronous to `clk`.
- Clear and sleep are pulses sampled on one edge.
- The deglitch and retry counts do not change while a bridge is qualifying or retrying.

The stimulus changes the counts only while every bridge is in IDLE, and it drives all inputs on the falling edge. Clear and sleep are raised for exactly one cycle, sometimes while flags are still high or while a persistence count is partly done.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_QUAL    = 2'd1,
        ST_LATCHED = 2'd2,
        ST_RETRY   = 2'd3
    } ocp_state_e;
endpackage

// File: rtl/ocp_bridge_fsm.sv
module ocp_bridge_fsm
    import ocp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FPB   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FPB-1:0]   flags_i,
    input  logic             retry_mode_i,
    input  logic             clr_i,
    input  logic             sleep_i,
    input  logic [CNT_W-1:0] deglitch_i,
    input  logic [CNT_W-1:0] retry_i,
    output logic             dis_o,
    output logic             trip_o,
    output logic [FPB-1:0]   trip_flags_o
);
    ocp_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_any;
    logic             trip;

    assign flag_any = |flags_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        trip    = 1'b0;
        if (sleep_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (flag_any) begin
                        if (deglitch_i == '0) begin
                            trip = 1'b1;
                        end else begin
                            state_d = ST_QUAL;
                            cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
                        end
                    end
                end
                ST_QUAL: begin
                    if (!flag_any) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q >= deglitch_i) begin
                        trip = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_LATCHED: begin
                    if (clr_i) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end
                ST_RETRY: begin
                    if (clr_i) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q >= retry_i) begin
                        if (flag_any) begin
                            cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
                        end else begin
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
            if (trip) begin
                state_d = retry_mode_i ? ST_RETRY : ST_LATCHED;
                cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        dis_o        = (state_q == ST_LATCHED) || (state_q == ST_RETRY);
        trip_o       = trip;
        trip_flags_o = trip ? flags_i : '0;
    end

    // R1
    trip_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_o) |-> $past(flag_any));

    // R6
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && !clr_i && !sleep_i) |=> (state_q == ST_LATCHED));

    // R8
    release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dis_o) |-> (!$past(flag_any) || $past(clr_i) || $past(sleep_i)));
endmodule

// File: rtl/ocp_fault_agg.sv
module ocp_fault_agg #(
    parameter int NB  = 2,
    parameter int FPB = 4,
    localparam int NF = NB * FPB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] trip_i,
    input  logic [NF-1:0] trip_flags_i,
    input  logic [NB-1:0] dis_i,
    input  logic          clr_i,
    input  logic          sleep_i,
    output logic          fault_o,
    output logic          fault_n_o,
    output logic          ocp_o,
    output logic [NF-1:0] diag_o
);
    logic          ocp_q;
    logic [NF-1:0] diag_q;
    logic          wipe;

    assign wipe = clr_i | sleep_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocp_q  <= 1'b0;
            diag_q <= '0;
        end else begin
            ocp_q  <= (ocp_q & ~wipe) | (|trip_i);
            diag_q <= (diag_q & {NF{~wipe}}) | trip_flags_i;
        end
    end

    always_comb begin
        fault_o   = |dis_i;
        fault_n_o = ~fault_o;
        ocp_o     = ocp_q;
        diag_o    = diag_q;
    end

    // R4
    fault_implies_ocp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ocp_o);

    // R4
    ocp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ocp_q) |-> $past(|trip_i));

    // R9
    diag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wipe) |-> ((diag_q & $past(diag_q)) == $past(diag_q)));
endmodule

// File: rtl/ocp_fault_handler.sv
module ocp_fault_handler #(
    parameter int NUM_BRIDGES     = 2,
    parameter int FETS_PER_BRIDGE = 4,
    parameter int CNT_W           = 16,
    localparam int NUM_FETS       = NUM_BRIDGES * FETS_PER_BRIDGE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_FETS-1:0]    ilim_i,
    input  logic                   retry_mode_i,
    input  logic                   clr_flt_i,
    input  logic                   sleep_rst_i,
    input  logic [CNT_W-1:0]       deglitch_cyc_i,
    input  logic [CNT_W-1:0]       retry_cyc_i,
    output logic [NUM_BRIDGES-1:0] bridge_dis_o,
    output logic                   fault_pin_n_o,
    output logic                   fault_o,
    output logic                   ocp_o,
    output logic [NUM_FETS-1:0]    fet_diag_o
);
    logic [NUM_BRIDGES-1:0] trip;
    logic [NUM_FETS-1:0]    trip_flags;

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
        ocp_bridge_fsm #(
            .CNT_W (CNT_W),
            .FPB   (FETS_PER_BRIDGE)
        ) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .flags_i      (ilim_i[b*FETS_PER_BRIDGE +: FETS_PER_BRIDGE]),
            .retry_mode_i (retry_mode_i),
            .clr_i        (clr_flt_i),
            .sleep_i      (sleep_rst_i),
            .deglitch_i   (deglitch_cyc_i),
            .retry_i      (retry_cyc_i),
            .dis_o        (bridge_dis_o[b]),
            .trip_o       (trip[b]),
            .trip_flags_o (trip_flags[b*FETS_PER_BRIDGE +: FETS_PER_BRIDGE])
        );
    end

    ocp_fault_agg #(
        .NB  (NUM_BRIDGES),
        .FPB (FETS_PER_BRIDGE)
    ) u_agg (
        .clk          (clk),
        .rst_n        (rst_n),
        .trip_i       (trip),
        .trip_flags_i (trip_flags),
        .dis_i        (bridge_dis_o),
        .clr_i        (clr_flt_i),
        .sleep_i      (sleep_rst_i),
        .fault_o      (fault_o),
        .fault_n_o    (fault_pin_n_o),
        .ocp_o        (ocp_o),
        .diag_o       (fet_diag_o)
    );
endmodule

// File: tb/sim_ocp_fault_handler.sv
`timescale 1ns/1ps
module sim_ocp_fault_handler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ilim = '0;
    logic        mode = 1'b0, clr = 1'b0, slp = 1'b0;
    logic [15:0] dgl = 16'd2, rty = 16'd3;
    logic [1:0]  dis;
    logic        fpin_n, flt, ocp;
    logic [7:0]  diag;
    int          n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    ocp_fault_handler u0 (
        .clk(clk), .rst_n(rst_n), .ilim_i(ilim), .retry_mode_i(mode),
        .clr_flt_i(clr), .sleep_rst_i(slp), .deglitch_cyc_i(dgl),
        .retry_cyc_i(rty), .bridge_dis_o(dis), .fault_pin_n_o(fpin_n),
        .fault_o(flt), .ocp_o(ocp), .fet_diag_o(diag)
    );

    // {req[4], flags[8], mode, clr, sleep, dis[2], fault, ocp, diag[8]}; D=2, R=3
    localparam int NV = 26;
    localparam logic [26:0] VEC [NV] = '{
        {4'd11, 8'h00, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00}, // R11 idle
        {4'd1,  8'h01, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00}, // R1 qual 1
        {4'd1,  8'h01, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00}, // R1 qual 2
        {4'd2,  8'h00, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00}, // R2 drop
        {4'd1,  8'h01, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00},
        {4'd1,  8'h01, 3'b000, 2'b00, 1'b0, 1'b0, 8'h00},
        {4'd1,  8'h01, 3'b000, 2'b01, 1'b1, 1'b1, 8'h01}, // R1 trip latched
        {4'd6,  8'h00, 3'b000, 2'b01, 1'b1, 1'b1, 8'h01}, // R6 hold
        {4'd6,  8'h00, 3'b000, 2'b01, 1'b1, 1'b1, 8'h01},
        {4'd10, 8'h00, 3'b010, 2'b00, 1'b0, 1'b0, 8'h00}, // R10 clear
        {4'd1,  8'h20, 3'b100, 2'b00, 1'b0, 1'b0, 8'h00},
        {4'd1,  8'h20, 3'b100, 2'b00, 1'b0, 1'b0, 8'h00},
        {4'd5,  8'h20, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20}, // R5 B out1 LS
        {4'd7,  8'h00, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20}, // R7 waiting
        {4'd7,  8'h00, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20},
        {4'd7,  8'h00, 3'b100, 2'b00, 1'b0, 1'b1, 8'h20}, // R7 resume
        {4'd9,  8'h20, 3'b100, 2'b00, 1'b0, 1'b1, 8'h20}, // R9 sticky
        {4'd9,  8'h20, 3'b100, 2'b00, 1'b0, 1'b1, 8'h20},
        {4'd8,  8'h20, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20},
        {4'd8,  8'h20, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20},
        {4'd8,  8'h20, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20},
        {4'd8,  8'h20, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20}, // R8 rearm
        {4'd8,  8'h00, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20},
        {4'd8,  8'h00, 3'b100, 2'b10, 1'b1, 1'b1, 8'h20},
        {4'd8,  8'h00, 3'b100, 2'b00, 1'b0, 1'b1, 8'h20},
        {4'd9,  8'h00, 3'b110, 2'b00, 1'b0, 1'b0, 8'h00}  // R9 cleared
    };

    task automatic cyc(input logic [7:0] f, input logic m, input logic c, input logic s);
        @(negedge clk);
        ilim = f; mode = m; clr = c; slp = s;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [1:0] e_dis, input logic e_flt,
                       input logic e_ocp, input logic [7:0] e_diag);
        n_tests++;
        if (dis !== e_dis || flt !== e_flt || fpin_n !== ~e_flt ||
            ocp !== e_ocp || diag !== e_diag) begin
            n_fail++;
            $display("FAIL %s: dis=%b flt=%b pin_n=%b ocp=%b diag=%h expected dis=%b flt=%b pin_n=%b ocp=%b diag=%h",
                     req, dis, flt, fpin_n, ocp, diag, e_dis, e_flt, ~e_flt, e_ocp, e_diag);
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R11", 2'b00, 1'b0, 1'b0, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12]);
            chk($sformatf("R%0d vec%0d", VEC[i][26:23], i),
                VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
        end

        // R10: sleep drops a partial persistence count
        cyc(8'h01, 1'b0, 1'b0, 1'b0);
        cyc(8'h01, 1'b0, 1'b0, 1'b0);
        cyc(8'h01, 1'b0, 1'b0, 1'b1);
        cyc(8'h01, 1'b0, 1'b0, 1'b0);
        cyc(8'h01, 1'b0, 1'b0, 1'b0);
        chk("R10 sleep restarts count", 2'b00, 1'b0, 1'b0, 8'h00);
        cyc(8'h01, 1'b0, 1'b0, 1'b0);
        chk("R1 trip after sleep", 2'b01, 1'b1, 1'b1, 8'h01);
        cyc(8'h00, 1'b0, 1'b0, 1'b1);
        chk("R10 sleep clears latched", 2'b00, 1'b0, 1'b0, 8'h00);

        // R5 / R3: two low-side flags on bridge A, bridge B untouched
        repeat (3) cyc(8'h0A, 1'b0, 1'b0, 1'b0);
        chk("R5 A LS bits, R3", 2'b01, 1'b1, 1'b1, 8'h0A);
        repeat (5) cyc(8'h00, 1'b1, 1'b0, 1'b0);
        chk("R6 mode change ignored", 2'b01, 1'b1, 1'b1, 8'h0A);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        chk("R10 clear", 2'b00, 1'b0, 1'b0, 8'h00);

        // R1 boundary: deglitch 0 trips on first edge
        @(negedge clk) dgl = 16'd0;
        cyc(8'h80, 1'b0, 1'b0, 1'b0);
        chk("R1 D=0 single edge", 2'b10, 1'b1, 1'b1, 8'h80);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        chk("R10 clear after D=0", 2'b00, 1'b0, 1'b0, 8'h00);
        @(negedge clk) dgl = 16'd2;

        // R3 / R4: both bridges together
        repeat (2) cyc(8'h11, 1'b0, 1'b0, 1'b0);
        chk("R3 both not yet", 2'b00, 1'b0, 1'b0, 8'h00);
        cyc(8'h11, 1'b0, 1'b0, 1'b0);
        chk("R4 both bridges", 2'b11, 1'b1, 1'b1, 8'h11);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        chk("R10 clear both", 2'b00, 1'b0, 1'b0, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule